// File: doc/BRIEF.md
# Host I/O Port Write Snoop FIFO

This block watches a decoded stream of host I/O write cycles and keeps a copy of the data byte of every write whose address hits one of two programmable 16-bit port numbers. Each kept byte goes into a 128-deep queue together with a one-bit tag. The tag says which port was hit, or, in double-word mode, marks the last byte of a four-port group. The management processor reads the queue through a small byte-wide register bus. Reading the data register removes the head entry.

A single interrupt output tells the processor that data is waiting or that the host reset line has toggled. The reset-toggle flag is sticky and is cleared by writing a one to it. When the queue is full, new bytes are discarded and a sticky overflow bit is set. That bit clears when the status register is read. In double-word mode the second port is not used. Writes to the base port and the three ports above it are kept, so POST codes wider than a byte can be followed.

Top module: `host_port_snoop`

## Requirements
- R1: After reset every register reads 0x00, the queue is empty and `irq` is low.
- R2: Register offsets: 0x02 port-B low byte, 0x04 port-B high byte, 0x06 control, 0x08 status, 0x0A data, 0x0C host status, 0x10 port-A low byte, 0x12 port-A high byte. Other offsets read 0x00. Control keeps only bits 7, 6, 4, 3 and 2, and the other bits read 0. A register write takes effect on the next clock, so a snoop in the same cycle still sees the old value.
- R3: With double-word mode off, a write strobe whose address equals port A while control bit 7 is set is queued with tag 0. An address equal to port B while control bit 6 is set is queued with tag 1. If both match, one entry with tag 0 is queued. Any other write is ignored.
- R4: Status reads {bit7 queue not empty, bit6 0, bit5 overflow, bits4..1 0, bit0 head tag (0 when empty)}. A read of the data register returns the head byte and removes it, so entries leave in arrival order.
- R5: A read of the data register while the queue is empty returns 0x00 and changes no state.
- R6: When the queue already holds 128 entries and no entry is removed in that cycle, a matching write is dropped and overflow (status bit 5) is set. Overflow stays set until a status read. If an overflow occurs in the same cycle as a status read, overflow remains set.
- R7: With control bit 2 set, port B is ignored. A write is queued when (address − port A) mod 65536 is 0 to 3. Its tag is 1 only for offset 3.
- R8: Each edge of `host_rst` sets host-status bit 6 on the third rising clock edge after it. Writing a 1 to bit 6 clears it. A set in the same cycle as the clear wins.
- R9: `irq` equals (control bit 3 AND queue not empty) OR (control bit 4 AND host-status bit 6).
- R10: A pop and an accepted push in the same cycle leave the entry count unchanged. At full, the pop frees room for that cycle's push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | One-cycle host I/O write strobe |
| io_addr | input | 16 | I/O port address of the write |
| io_data | input | 8 | Data byte of the write |
| host_rst | input | 1 | Asynchronous host reset level |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The sensitive overlaps are a host capture and a processor pop in the same cycle, and a sticky-flag set against its clear. The bench pops the data register while a matching write hits an already full queue, and checks that the byte is accepted and the count stays at 128. It then provokes an overflow together with a status read and expects bit 5 to stay set. A reset-line edge is timed so that its flag set coincides with the write-one clear, and the flag must survive. Each cycle is judged by a queue-based reference model that compares `reg_rdata` and `irq`.

// File: rtl/host_port_snoop.sv
module host_port_snoop #(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_data,
  input  logic        host_rst,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0]   FULLC = DEPTH[PW:0];
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
  localparam logic [4:0] OFS_BL = 5'h02, OFS_BH = 5'h04, OFS_CTL = 5'h06,
                         OFS_STAT = 5'h08, OFS_DATA = 5'h0A, OFS_HST = 5'h0C,
                         OFS_AL = 5'h10, OFS_AH = 5'h12;

  logic [7:0] al, ah, bl, bh, ctl;
  logic [8:0] mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [PW:0] cnt;
  logic ovf, chg;
  logic [2:0] hs;

  wire [15:0] pa = {ah, al};
  wire [15:0] pb = {bh, bl};
  wire        dw = ctl[2];
  wire [15:0] off = io_addr - pa;
  wire hit_a = ctl[7] && !dw && io_addr == pa;
  wire hit_b = ctl[6] && !dw && io_addr == pb;
  wire hit_d = dw && off < 16'd4;
  wire hit   = io_wr && (hit_a || hit_b || hit_d);
  wire tag   = dw ? (off == 16'd3) : !hit_a;
  wire empty = cnt == '0;
  wire full  = cnt == FULLC;
  wire pop   = reg_rd && reg_addr == OFS_DATA && !empty;
  wire push  = hit && (!full || pop);
  wire drop  = hit && full && !pop;
  wire stat_rd = reg_rd && reg_addr == OFS_STAT;
  wire chg_clr = reg_wr && reg_addr == OFS_HST && reg_wdata[6];
  wire [8:0] head = mem[rp];

  assign irq = (ctl[3] && !empty) || (ctl[4] && chg);

  always_comb begin
    case (reg_addr)
      OFS_BL:   reg_rdata = bl;
      OFS_BH:   reg_rdata = bh;
      OFS_CTL:  reg_rdata = ctl;
      OFS_STAT: reg_rdata = {!empty, 1'b0, ovf, 4'b0, !empty && head[8]};
      OFS_DATA: reg_rdata = empty ? 8'h00 : head[7:0];
      OFS_HST:  reg_rdata = {1'b0, chg, 6'b0};
      OFS_AL:   reg_rdata = al;
      OFS_AH:   reg_rdata = ah;
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {al, ah, bl, bh, ctl} <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_AL:  al  <= reg_wdata;
        OFS_AH:  ah  <= reg_wdata;
        OFS_BL:  bl  <= reg_wdata;
        OFS_BH:  bh  <= reg_wdata;
        OFS_CTL: ctl <= reg_wdata & 8'hDC;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {tag, io_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0; ovf <= 1'b0;
    end else begin
      if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
      ovf <= drop || (ovf && !stat_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs <= '0; chg <= 1'b0;
    end else begin
      hs  <= {hs[1:0], host_rst};
      chg <= (hs[2] ^ hs[1]) || (chg && !chg_clr);
    end
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLC);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !stat_rd |=> ovf);
  a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(io_wr && cnt == FULLC));
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    empty && reg_rd && reg_addr == OFS_DATA && !io_wr |=> empty);
  a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(cnt));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    chg && !chg_clr |=> chg);
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!empty || chg));
endmodule

// File: tb/tb_host_port_snoop.sv
`timescale 1ns/1ps
module tb_host_port_snoop;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0, host_rst = 0, reg_wr = 0, reg_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_data = 0, reg_wdata = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  host_port_snoop dut (.*);
  always #4 clk = ~clk;

  // reference model state
  int q_d[$];
  int q_t[$];
  logic [7:0] m_al, m_ah, m_bl, m_bh, m_ctl;
  bit m_ovf, m_chg, h1, h2, h3;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rdata(input logic [4:0] a);
    bit ne = q_d.size() > 0;
    case (a)
      5'h02: return m_bl;
      5'h04: return m_bh;
      5'h06: return m_ctl;
      5'h08: return {ne, 1'b0, m_ovf, 4'b0, ne ? q_t[0][0] : 1'b0};
      5'h0A: return ne ? 8'(q_d[0]) : 8'h00;
      5'h0C: return {1'b0, m_chg, 6'b0};
      5'h10: return m_al;
      5'h12: return m_ah;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc(input string req);
    logic [15:0] pa, pb, off;
    bit hit, tg, pop, full, set;
    @(negedge clk);
    chk({req, " rdata"}, reg_rdata, m_rdata(reg_addr));
    chk("R9 irq", irq, (m_ctl[3] && q_d.size() > 0) || (m_ctl[4] && m_chg));
    @(posedge clk);
    pa = {m_ah, m_al}; pb = {m_bh, m_bl}; off = io_addr - pa;
    if (m_ctl[2]) begin hit = io_wr && off < 4; tg = off == 3; end
    else if (m_ctl[7] && io_addr == pa) begin hit = io_wr; tg = 0; end
    else if (m_ctl[6] && io_addr == pb) begin hit = io_wr; tg = 1; end
    else begin hit = 0; tg = 0; end
    pop  = reg_rd && reg_addr == 5'h0A && q_d.size() > 0;
    full = q_d.size() == 128;
    if (reg_rd && reg_addr == 5'h08) m_ovf = 0;
    if (hit && full && !pop) m_ovf = 1;
    if (pop) begin void'(q_d.pop_front()); void'(q_t.pop_front()); end
    if (hit && (!full || pop)) begin q_d.push_back(io_data); q_t.push_back(tg); end
    set = h2 != h3;
    m_chg = set || (m_chg && !(reg_wr && reg_addr == 5'h0C && reg_wdata[6]));
    h3 = h2; h2 = h1; h1 = host_rst;
    if (reg_wr) case (reg_addr)
      5'h02: m_bl = reg_wdata;
      5'h04: m_bh = reg_wdata;
      5'h06: m_ctl = reg_wdata & 8'hDC;
      5'h10: m_al = reg_wdata;
      5'h12: m_ah = reg_wdata;
      default: ;
    endcase
    #1;
  endtask

  task automatic clr();
    io_wr = 0; reg_wr = 0; reg_rd = 0;
  endtask
  task automatic wreg(input logic [4:0] a, input logic [7:0] v, input string req);
    reg_addr = a; reg_wdata = v; reg_wr = 1; cyc(req); clr();
  endtask
  task automatic rreg(input logic [4:0] a, input string req);
    reg_addr = a; reg_rd = 1; cyc(req); clr();
  endtask
  task automatic snoop(input logic [15:0] a, input logic [7:0] d, input string req);
    io_addr = a; io_data = d; io_wr = 1; cyc(req); clr();
  endtask
  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    {m_al, m_ah, m_bl, m_bh, m_ctl} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1; #1;
    // R1: reset state of all registers
    for (int a = 0; a < 20; a += 2) begin reg_addr = 5'(a); cyc("R1"); end
    chk("R1 irq", irq, 0);
    // R2: map, control mask, read-back
    wreg(5'h10, 8'h80, "R2"); wreg(5'h12, 8'h00, "R2");
    wreg(5'h02, 8'h84, "R2"); wreg(5'h04, 8'h00, "R2");
    wreg(5'h06, 8'hFF, "R2");
    reg_addr = 5'h06; cyc("R2"); chk("R2 ctl mask", reg_rdata, 8'hDC);
    // R2: snoop in same cycle as enable write uses old (dw) setting
    reg_addr = 5'h06; reg_wdata = 8'hC8; reg_wr = 1;
    io_addr = 16'h0084; io_data = 8'h5A; io_wr = 1; cyc("R2"); clr();
    reg_addr = 5'h08; cyc("R2");
    // R3: both ports, tags, mismatch ignored
    snoop(16'h0080, 8'h11, "R3"); snoop(16'h0084, 8'h22, "R3");
    snoop(16'h0081, 8'h33, "R3"); snoop(16'h1080, 8'h44, "R3");
    reg_addr = 5'h08; cyc("R4");
    // R4: ordered pops with tags
    for (int i = 0; i < 3; i++) begin rreg(5'h08, "R4"); rreg(5'h0A, "R4"); end
    // R5: empty data read
    rreg(5'h0A, "R5"); reg_addr = 5'h0A; cyc("R5");
    chk("R5 empty", reg_rdata, 8'h00);
    // R3: same address on both ports gives one entry tag 0
    wreg(5'h02, 8'h80, "R3");
    snoop(16'h0080, 8'h66, "R3");
    reg_addr = 5'h08; cyc("R3"); chk("R3 dual tag", reg_rdata, 8'h80);
    rreg(5'h0A, "R3"); reg_addr = 5'h08; cyc("R3");
    // R6: fill, overflow, concurrent pop
    for (int i = 0; i < 128; i++) snoop(16'h0080, 8'(i), "R6");
    snoop(16'h0080, 8'hEE, "R6");
    reg_addr = 5'h08; cyc("R6"); chk("R6 ovf", reg_rdata, 8'hA0);
    // R10: pop + push at full
    reg_addr = 5'h0A; reg_rd = 1; io_addr = 16'h0080; io_data = 8'hF0; io_wr = 1;
    cyc("R10"); clr();
    rreg(5'h08, "R6"); reg_addr = 5'h08; cyc("R6");
    chk("R6 ovf cleared", reg_rdata, 8'h80);
    // R6: overflow with status read in same cycle stays set
    reg_addr = 5'h08; reg_rd = 1; io_addr = 16'h0080; io_data = 8'hF1; io_wr = 1;
    cyc("R6"); clr();
    reg_addr = 5'h08; cyc("R6"); chk("R6 set wins", reg_rdata, 8'hA0);
    for (int i = 0; i < 128; i++) rreg(5'h0A, "R4");
    rreg(5'h08, "R6");
    // R7: double-word mode with wrapping base
    wreg(5'h10, 8'hFE, "R7"); wreg(5'h12, 8'hFF, "R7");
    wreg(5'h02, 8'h02, "R7"); wreg(5'h04, 8'h00, "R7");
    wreg(5'h06, 8'h0C, "R7");
    snoop(16'h0002, 8'h99, "R7");
    snoop(16'hFFFE, 8'hA1, "R7"); snoop(16'hFFFF, 8'hA2, "R7");
    snoop(16'h0000, 8'hA3, "R7"); snoop(16'h0001, 8'hA4, "R7");
    snoop(16'hFFFD, 8'hA5, "R7");
    for (int i = 0; i < 4; i++) begin rreg(5'h08, "R7"); rreg(5'h0A, "R7"); end
    reg_addr = 5'h08; cyc("R7"); chk("R7 drained", reg_rdata, 8'h00);
    // R8/R9: host reset edge, interrupt, W1C
    wreg(5'h06, 8'h10, "R8");
    host_rst = 1; reg_addr = 5'h0C; idle(4, "R8");
    chk("R8 flag", reg_rdata, 8'h40); chk("R9 irq", irq, 1);
    wreg(5'h0C, 8'hBF, "R8"); idle(1, "R8");
    wreg(5'h0C, 8'h40, "R8"); idle(1, "R8");
    chk("R8 cleared", reg_rdata, 8'h00);
    // R8: set coincides with clear
    host_rst = 0; cyc("R8"); cyc("R8");
    wreg(5'h0C, 8'h40, "R8"); reg_addr = 5'h0C; cyc("R8");
    chk("R8 set wins", reg_rdata, 8'h40);
    idle(3, "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule